// File: doc/BRIEF.md
# Call and Interrupt Context Stacker

This block moves processor context between a set of register inputs and a byte-wide stack memory. It runs one command at a time and makes one memory access per clock. A subroutine call stores a 16-bit return address. A subroutine return reads that address back. Interrupt entry stores a nine-byte context frame that holds the return address, the X and Y index words, the A and B accumulators and the condition code byte. Interrupt return reads the whole frame back. A wait-for-interrupt command stores the same frame as interrupt entry and then parks until `irq_i` arrives.

When a command is accepted, the block captures the stack pointer and the context inputs. It walks the stack and drives the running stack pointer on `sp_o`. At completion it pulses `done_o`. Pull commands also raise `restore_valid_o` together with the restored register values. Stores go downward: each write lands at the current pointer, and the pointer then decrements. Loads go upward: the pointer increments first, and the byte is then read at the new value. All pointer arithmetic wraps modulo 2^ADDR_W.

Top module: `ctx_stacker`

## Requirements
- R1: Call (cmd_i=0) writes the return-address low byte at SP and the high byte at SP-1, and ends with sp_o = SP-2.
- R2: Return (cmd_i=1) reads the high byte at SP+1 and the low byte at SP+2. It ends with sp_o = SP+2 and pc_o equal to the restored address, and restore_valid_o is high in the done cycle.
- R3: Interrupt entry (cmd_i=2) writes, at SP, SP-1, ..., SP-8, the bytes PC low, PC high, Y low, Y high, X low, X high, A, B, CCR, and ends with sp_o = SP-9.
- R4: Interrupt return (cmd_i=4) reads SP+1..SP+9 as CCR, B, A, X high, X low, Y high, Y low, PC high, PC low. It restores every field from memory, not from the inputs, and ends with sp_o = SP+9.
- R5: Wait (cmd_i=3) writes the same frame as R3 and then holds waiting_o and busy_o high with no memory access until irq_i is sampled high. done_o pulses in the following cycle.
- R6: Each command makes exactly one memory access per cycle. busy_o is high from the cycle after acceptance through the final access. done_o is then high for exactly one cycle with busy_o low, and mem_we_o and mem_re_o are never high together.
- R7: cmd_valid_i is ignored while busy_o is high, including while parked. It causes no extra memory access and no change to sp_o.
- R8: Stack pointer arithmetic wraps modulo 2^ADDR_W: a call at 0x0000 writes 0x0000 and 0xFFFF, and a return from 0xFFFE reads 0xFFFF and 0x0000.
- R9: After reset, busy_o, done_o, waiting_o, restore_valid_o, mem_we_o and mem_re_o are low and sp_o is 0.
- R10: irq_i has no effect when the block is not parked.
- R11: cmd_i codes 5 to 7 are not accepted: no busy, no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 3 | Command code |
| irq_i | input | 1 | Interrupt request that releases the parked state |
| pc_i | input | 16 | Return address to store |
| x_i | input | 16 | X index word |
| y_i | input | 16 | Y index word |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| ccr_i | input | 8 | Condition code byte |
| sp_i | input | ADDR_W | Starting stack pointer |
| mem_addr_o | output | ADDR_W | Stack memory address |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe; data is expected on mem_rdata_i in the same cycle |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte |
| sp_o | output | ADDR_W | Running stack pointer |
| busy_o | output | 1 | Command in progress or parked |
| done_o | output | 1 | One-cycle completion pulse |
| waiting_o | output | 1 | Parked after a wait command |
| restore_valid_o | output | 1 | Restored values valid (pull commands, done cycle) |
| pc_o | output | 16 | Restored return address |
| x_o | output | 16 | Restored X |
| y_o | output | 16 | Restored Y |
| a_o | output | 8 | Restored A |
| b_o | output | 8 | Restored B |
| ccr_o | output | 8 | Restored condition codes |

## Verification
The bench uses the default ADDR_W of 16. This makes the full address space wrap between 0x0000 and 0xFFFF, so a call at the bottom of memory and the return that follows cross the boundary in both directions. With the full 16-bit pointer, the frames at other addresses sit far apart and do not overlap. The memory model records every write and read address. Frame order, start and end pointers, and the absence of accesses during a park or a stray command can therefore all be checked at the ports.

// File: rtl/ctx_stacker_pkg.sv
package ctx_stacker_pkg;
  typedef enum logic [2:0] {
    CMD_CALL = 3'd0,
    CMD_RET  = 3'd1,
    CMD_INT  = 3'd2,
    CMD_WAIT = 3'd3,
    CMD_RTI  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PARK, ST_DONE} state_e;

  localparam int unsigned FRAME_BYTES = 9;
  localparam int unsigned RTN_BYTES   = 2;
  localparam int unsigned IDX_W       = $clog2(FRAME_BYTES + 1);
  localparam int unsigned WORD_W      = 16;
endpackage

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_stacker_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic             irq_i,
  output logic             start_o,
  output logic             push_o,
  output logic             pull_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             waiting_o,
  output logic             restored_o
);
  state_e           state_q;
  logic [IDX_W-1:0] step_q, last_q, last_d;
  logic             pull_q, park_q, pull_d, park_d, legal;

  always_comb begin
    legal  = 1'b1;
    pull_d = 1'b0;
    park_d = 1'b0;
    last_d = IDX_W'(FRAME_BYTES - 1);
    case (cmd_e'(cmd_i))
      CMD_CALL: last_d = IDX_W'(RTN_BYTES - 1);
      CMD_RET:  begin last_d = IDX_W'(RTN_BYTES - 1); pull_d = 1'b1; end
      CMD_INT:  ;
      CMD_WAIT: park_d = 1'b1;
      CMD_RTI:  pull_d = 1'b1;
      default:  legal = 1'b0;
    endcase
  end

  assign busy_o     = (state_q == ST_RUN) || (state_q == ST_PARK);
  assign done_o     = (state_q == ST_DONE);
  assign waiting_o  = (state_q == ST_PARK);
  assign start_o    = !busy_o && cmd_valid_i && legal;
  assign push_o     = (state_q == ST_RUN) && !pull_q;
  assign pull_o     = (state_q == ST_RUN) && pull_q;
  assign restored_o = done_o && pull_q;
  // pulls walk the frame from the far end back
  assign idx_o      = pull_q ? (last_q - step_q) : step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      last_q  <= '0;
      pull_q  <= 1'b0;
      park_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (step_q == last_q) state_q <= park_q ? ST_PARK : ST_DONE;
          else step_q <= step_q + 1'b1;
        end
        ST_PARK: if (irq_i) state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
      if (start_o) begin
        state_q <= ST_RUN;
        step_q  <= '0;
        last_q  <= last_d;
        pull_q  <= pull_d;
        park_q  <= park_d;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R5
  park_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_o && !irq_i |=> waiting_o && !push_o && !pull_o);
  // R10
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !cmd_valid_i |=> !busy_o && !done_o);
endmodule

// File: rtl/ctx_sp.sv
module ctx_sp #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              push_i,
  input  logic              pull_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] sp_q;

  assign sp_o   = sp_q;
  // pre-increment on pull, post-decrement on push
  assign addr_o = pull_i ? sp_q + ADDR_W'(1) : sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (start_i) sp_q <= sp_i;
    else if (push_i)  sp_q <= sp_q - ADDR_W'(1);
    else if (pull_i)  sp_q <= sp_q + ADDR_W'(1);
  end

  // R1 R8
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !start_i |=> sp_o == $past(addr_o) - ADDR_W'(1));
  // R2 R8
  pull_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_i && !start_i |=> sp_o == $past(addr_o));
endmodule

// File: rtl/ctx_frame.sv
module ctx_frame
  import ctx_stacker_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [7:0]        a_i,
  input  logic [7:0]        b_i,
  input  logic [7:0]        ccr_i,
  input  logic              push_i,
  input  logic              pull_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        rdata_i,
  output logic [7:0]        wdata_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] x_o,
  output logic [WORD_W-1:0] y_o,
  output logic [7:0]        a_o,
  output logic [7:0]        b_o,
  output logic [7:0]        ccr_o
);
  logic [FRAME_BYTES-1:0][7:0] frm_q, frm_in;
  logic                        idx_ok;

  // byte 0 is stored first (highest address)
  assign frm_in = {ccr_i, b_i, a_i, x_i[15:8], x_i[7:0],
                   y_i[15:8], y_i[7:0], pc_i[15:8], pc_i[7:0]};
  assign idx_ok  = idx_i < IDX_W'(FRAME_BYTES);
  assign wdata_o = idx_ok ? frm_q[idx_i] : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 frm_q <= '0;
    else if (start_i)            frm_q <= frm_in;
    else if (pull_i && idx_ok)   frm_q[idx_i] <= rdata_i;
  end

  assign pc_o  = {frm_q[1], frm_q[0]};
  assign y_o   = {frm_q[3], frm_q[2]};
  assign x_o   = {frm_q[5], frm_q[4]};
  assign a_o   = frm_q[6];
  assign b_o   = frm_q[7];
  assign ccr_o = frm_q[8];

  // R3 R4
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i || pull_i |-> idx_ok);
endmodule

// File: rtl/ctx_stacker.sv
module ctx_stacker
  import ctx_stacker_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic              irq_i,
  input  logic [15:0]       pc_i,
  input  logic [15:0]       x_i,
  input  logic [15:0]       y_i,
  input  logic [7:0]        a_i,
  input  logic [7:0]        b_i,
  input  logic [7:0]        ccr_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              waiting_o,
  output logic              restore_valid_o,
  output logic [15:0]       pc_o,
  output logic [15:0]       x_o,
  output logic [15:0]       y_o,
  output logic [7:0]        a_o,
  output logic [7:0]        b_o,
  output logic [7:0]        ccr_o
);
  logic             start, push, pull;
  logic [IDX_W-1:0] idx;

  ctx_seq u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .irq_i,
    .start_o(start), .push_o(push), .pull_o(pull), .idx_o(idx),
    .busy_o, .done_o, .waiting_o, .restored_o(restore_valid_o)
  );

  ctx_sp #(.ADDR_W(ADDR_W)) u_sp (
    .clk_i, .rst_ni, .start_i(start), .sp_i,
    .push_i(push), .pull_i(pull), .sp_o, .addr_o(mem_addr_o)
  );

  ctx_frame u_frame (
    .clk_i, .rst_ni, .start_i(start),
    .pc_i, .x_i, .y_i, .a_i, .b_i, .ccr_i,
    .push_i(push), .pull_i(pull), .idx_i(idx), .rdata_i(mem_rdata_i),
    .wdata_o(mem_wdata_o), .pc_o, .x_o, .y_o, .a_o, .b_o, .ccr_o
  );

  assign mem_we_o = push;
  assign mem_re_o = pull;

  // R6
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$past(done_o) && (mem_we_o || mem_re_o) |=> !done_o || !(mem_we_o || mem_re_o));
endmodule

// File: tb/ctx_stacker_test.sv
module ctx_stacker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic        irq_i = 1'b0;
  logic [15:0] pc_i = '0, x_i = '0, y_i = '0, sp_i = '0;
  logic [7:0]  a_i = '0, b_i = '0, ccr_i = '0;
  logic [15:0] mem_addr_o, sp_o, pc_o, x_o, y_o;
  logic        mem_we_o, mem_re_o, busy_o, done_o, waiting_o, restore_valid_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i, a_o, b_o, ccr_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0]  mem [256];
  logic [15:0] wa [64];
  logic [7:0]  wd [64];
  logic [15:0] ra [64];
  int wn = 0, rn = 0;

  always #5 clk_i = ~clk_i;

  ctx_stacker uut (.*);

  assign mem_rdata_i = mem[mem_addr_o[7:0]];
  always @(posedge clk_i) begin
    if (mem_we_o) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o;
      wa[wn % 64] <= mem_addr_o;
      wd[wn % 64] <= mem_wdata_o;
      wn <= wn + 1;
    end
    if (mem_re_o) begin
      ra[rn % 64] <= mem_addr_o;
      rn <= rn + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // issue a command and count busy cycles until done or park
  task automatic run(input logic [2:0] c, input logic [15:0] sp, input logic [15:0] pc,
                     input logic [15:0] x, input logic [15:0] y, input logic [7:0] a,
                     input logic [7:0] b, input logic [7:0] cc, input bit hammer,
                     output int cyc);
    @(negedge clk_i);
    cmd_i = c; sp_i = sp; pc_i = pc; x_i = x; y_i = y; a_i = a; b_i = b; ccr_i = cc;
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    cyc = 0;
    while (busy_o && !waiting_o && cyc < 40) begin
      cyc++;
      if (hammer) begin cmd_valid_i = 1'b1; cmd_i = 3'd0; sp_i = 16'h0AA0; end
      @(negedge clk_i);
    end
    cmd_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 busy", busy_o, 0);
    chk("R9 done", done_o, 0);
    chk("R9 waiting", waiting_o, 0);
    chk("R9 valid", restore_valid_o, 0);
    chk("R9 sp", sp_o, 0);
    chk("R9 access", {mem_we_o, mem_re_o}, 0);
  endtask

  task automatic t_call_ret;
    int cyc, w0, r0;
    w0 = wn;
    run(3'd0, 16'h0180, 16'h1234, 0, 0, 0, 0, 0, 0, cyc);
    chk("R6 call cycles", cyc, 2);
    chk("R6 call done", {done_o, busy_o}, 2'b10);
    chk("R1 writes", wn - w0, 2);
    chk("R1 low addr", wa[w0 % 64], 16'h0180);
    chk("R1 low data", wd[w0 % 64], 8'h34);
    chk("R1 high addr", wa[(w0 + 1) % 64], 16'h017F);
    chk("R1 high data", wd[(w0 + 1) % 64], 8'h12);
    chk("R1 sp", sp_o, 16'h017E);
    chk("R2 no valid on push", restore_valid_o, 0);
    @(negedge clk_i);
    chk("R6 done one cycle", done_o, 0);
    r0 = rn;
    run(3'd1, 16'h017E, 16'h0000, 0, 0, 0, 0, 0, 0, cyc);
    chk("R2 cycles", cyc, 2);
    chk("R2 valid", {restore_valid_o, done_o}, 2'b11);
    chk("R2 pc", pc_o, 16'h1234);
    chk("R2 sp", sp_o, 16'h0180);
    chk("R2 first read", ra[r0 % 64], 16'h017F);
    chk("R2 second read", ra[(r0 + 1) % 64], 16'h0180);
  endtask

  task automatic t_int_rti;
    int cyc, w0, r0;
    logic [7:0] exp_b [9] = '{8'hB2, 8'hA1, 8'hF6, 8'hE5, 8'hD4, 8'hC3, 8'h11, 8'h22, 8'h33};
    w0 = wn;
    // hammer exercises R7: calls offered while busy
    run(3'd2, 16'h01F0, 16'hA1B2, 16'hC3D4, 16'hE5F6, 8'h11, 8'h22, 8'h33, 1, cyc);
    chk("R6 int cycles", cyc, 9);
    chk("R7 writes", wn - w0, 9);
    for (int i = 0; i < 9; i++) begin
      chk("R3 addr", wa[(w0 + i) % 64], 16'h01F0 - 16'(i));
      chk("R3 data", wd[(w0 + i) % 64], exp_b[i]);
    end
    chk("R3 sp", sp_o, 16'h01E7);
    @(negedge clk_i);
    chk("R7 no late start", {busy_o, wn - w0}, {1'b0, 32'd9});
    r0 = rn;
    run(3'd4, 16'h01E7, 0, 0, 0, 0, 0, 0, 0, cyc);
    chk("R4 cycles", cyc, 9);
    chk("R4 valid", restore_valid_o, 1);
    chk("R4 pc", pc_o, 16'hA1B2);
    chk("R4 x", x_o, 16'hC3D4);
    chk("R4 y", y_o, 16'hE5F6);
    chk("R4 a", a_o, 8'h11);
    chk("R4 b", b_o, 8'h22);
    chk("R4 ccr", ccr_o, 8'h33);
    chk("R4 sp", sp_o, 16'h01F0);
    chk("R4 first read", ra[r0 % 64], 16'h01E8);
    chk("R4 last read", ra[(r0 + 8) % 64], 16'h01F0);
  endtask

  task automatic t_wait;
    int cyc, w0;
    w0 = wn;
    run(3'd3, 16'h0050, 16'h0102, 16'h0304, 16'h0506, 8'h07, 8'h08, 8'h09, 0, cyc);
    chk("R5 push cycles", cyc, 9);
    chk("R5 writes", wn - w0, 9);
    chk("R5 first", {wa[w0 % 64], wd[w0 % 64]}, {16'h0050, 8'h02});
    chk("R5 ccr", {wa[(w0 + 8) % 64], wd[(w0 + 8) % 64]}, {16'h0048, 8'h09});
    chk("R5 parked", {waiting_o, busy_o, done_o}, 3'b110);
    cmd_valid_i = 1'b1; cmd_i = 3'd0; sp_i = 16'h0100;
    repeat (3) @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk("R5 still parked", {waiting_o, done_o}, 2'b10);
    chk("R7 no access while parked", wn - w0, 9);
    chk("R7 sp while parked", sp_o, 16'h0047);
    irq_i = 1'b1;
    @(negedge clk_i);
    irq_i = 1'b0;
    chk("R5 release", {done_o, waiting_o, busy_o}, 3'b100);
  endtask

  task automatic t_wrap;
    int cyc, w0, r0;
    w0 = wn;
    run(3'd0, 16'h0000, 16'hBEEF, 0, 0, 0, 0, 0, 0, cyc);
    chk("R8 low addr", wa[w0 % 64], 16'h0000);
    chk("R8 high addr", wa[(w0 + 1) % 64], 16'hFFFF);
    chk("R8 sp", sp_o, 16'hFFFE);
    r0 = rn;
    run(3'd1, 16'hFFFE, 0, 0, 0, 0, 0, 0, 0, cyc);
    chk("R8 read high", ra[r0 % 64], 16'hFFFF);
    chk("R8 read low", ra[(r0 + 1) % 64], 16'h0000);
    chk("R8 pc", pc_o, 16'hBEEF);
    chk("R8 sp back", sp_o, 16'h0000);
  endtask

  task automatic t_ignored;
    int w0;
    w0 = wn;
    @(negedge clk_i);
    irq_i = 1'b1;
    @(negedge clk_i);
    irq_i = 1'b0;
    chk("R10 irq idle", {busy_o, done_o}, 2'b00);
    @(negedge clk_i);
    chk("R10 irq idle later", {busy_o, done_o}, 2'b00);
    cmd_i = 3'd7; cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk("R11 bad code", {busy_o, mem_we_o, mem_re_o}, 3'b000);
    chk("R11 no writes", wn - w0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_call_ret();
    t_int_rti();
    t_wait();
    t_wrap();
    t_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule